// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides a fast input clock by a programmable ratio N = 4·(B·P + A). It is the feedback path of a frequency synthesizer. A dual-modulus prescaler divides by P+1 or by P. A swallow counter (A, 6 bits) and a main counter (B, 13 bits) choose between the two moduli. A fixed divide-by-4 stage follows them. The divider emits a one-cycle pulse once per N input cycles. The prescaler is modelled in synchronous logic, so every stage runs on the same input clock.

Software presents A, B and a 2-bit prescaler code, then strobes `load`. The block checks the setting as it arrives. A legal setting is parked as pending and becomes active only when the current output period ends. An illegal setting raises `cfg_err` and is discarded, and the divider keeps its current ratio. Starting from 4·(P² − P), every multiple of four can be reached with a legal setting. Below that bound, the rule B ≥ A leaves gaps.

Top module: `pswl_divider`

## Requirements
- R1: After a synchronous active-low reset, `div_pulse` and `cfg_err` are 0 and the ratio is the parameter default (A=0, B=2, code 0), giving a first pulse 64 input cycles after reset is released.
- R2: With a setting active, `div_pulse` is high in exactly one cycle out of every N = 4·(B·P + A) input cycles.
- R3: Prescaler code 0, 1, 2, 3 selects P = 8, 16, 32, 64 (moduli 8/9, 16/17, 32/33, 64/65).
- R4: Within each B cycle, the prescaler divides by P+1 for the first A of its outputs and by P for the remaining B−A outputs.
- R5: A load with B < 2 sets `cfg_err` on the next cycle and leaves the running ratio unchanged.
- R6: A load with B < A sets `cfg_err` on the next cycle and leaves the running ratio unchanged.
- R7: A legal load clears `cfg_err` on the next cycle, and `cfg_err` changes only on a load.
- R8: A legal setting takes effect at the first output-period boundary after the load. The period in progress completes with the old ratio, and a later legal load before that boundary replaces the pending one.
- R9: `div_pulse` is never high for two consecutive cycles.
- R10: With P = 8, every ratio 4·56 through 4·63 (from 4·(P² − P) upward) is reached by a legal setting and produces its exact period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Synchronous active-low reset |
| load | input | 1 | Strobe that samples the three setting inputs |
| a_val | input | 6 | Swallow count A |
| b_val | input | 13 | Main count B |
| pre_sel | input | 2 | Prescaler modulus code |
| div_pulse | output | 1 | One-cycle pulse per N input cycles |
| cfg_err | output | 1 | Last load was illegal |

## Verification
The bench tracks every period edge against its own cycle count. A design that applied a new setting at once would produce one shortened or stretched period, and the bench would see the pulse arrive early or late. Illegal loads go in with B=1 and with B below A, one of each directly after a legal load. A divider that accepted either one would change period, and an error flag that was not sticky, or not cleared by a legal load, would differ in the cycle after the strobe. The sweep from 4·56 to 4·63 includes A = B − 0 style edge cases such as B=7, A=7. Swapping the P and P+1 phases, or miscounting the swallow, shows up there as a period that is off by A or by B.

// File: rtl/pswl_pkg.sv
package pswl_pkg;

   // Base prescaler modulus for a select code: 2^(log2_min + code)
   function automatic int unsigned pre_modulus(input int unsigned code,
                                               input int unsigned log2_min);
      return 32'd1 << (log2_min + code);
   endfunction

endpackage

// File: rtl/pswl_cfg.sv
module pswl_cfg #(
   parameter int A_W      = 6,
   parameter int B_W      = 13,
   parameter int PSEL_W   = 2,
   parameter int RST_A    = 0,
   parameter int RST_B    = 2,
   parameter int RST_PSEL = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [A_W-1:0]    a_in,
   input  logic [B_W-1:0]    b_in,
   input  logic [PSEL_W-1:0] psel_in,
   input  logic              boundary,
   output logic [A_W-1:0]    a_act,
   output logic [B_W-1:0]    b_act,
   output logic [PSEL_W-1:0] psel_act,
   output logic              cfg_err
);
   logic [A_W-1:0]    a_pend;
   logic [B_W-1:0]    b_pend;
   logic [PSEL_W-1:0] psel_pend;
   logic              pend_v;
   logic              legal;

   assign legal = (b_in >= B_W'(2)) && (B_W'(a_in) <= b_in);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_act     <= A_W'(RST_A);
         b_act     <= B_W'(RST_B);
         psel_act  <= PSEL_W'(RST_PSEL);
         a_pend    <= A_W'(RST_A);
         b_pend    <= B_W'(RST_B);
         psel_pend <= PSEL_W'(RST_PSEL);
         pend_v    <= 1'b0;
         cfg_err   <= 1'b0;
      end else begin
         if (boundary && pend_v) begin
            a_act    <= a_pend;
            b_act    <= b_pend;
            psel_act <= psel_pend;
            pend_v   <= 1'b0;
         end
         if (load) begin
            cfg_err <= !legal;
            if (legal) begin
               a_pend    <= a_in;
               b_pend    <= b_in;
               psel_pend <= psel_in;
               pend_v    <= 1'b1;
            end
         end
      end
   end

   p_hold_until_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !boundary |=> ($stable(a_act) && $stable(b_act) && $stable(psel_act)));

   p_active_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (b_act >= B_W'(2)));

   p_active_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (B_W'(a_act) <= b_act));

   p_err_on_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(cfg_err));
endmodule

// File: rtl/pswl_prescaler.sv
module pswl_prescaler #(
   parameter int PC_W     = 7,
   parameter int PSEL_W   = 2,
   parameter int LOG2_MIN = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PSEL_W-1:0] psel,
   input  logic              swallow,
   output logic              pre_tick
);
   import pswl_pkg::*;

   logic [PC_W-1:0] cnt;
   logic [PC_W-1:0] modv;

   assign modv     = PC_W'(pre_modulus(int'(psel), LOG2_MIN)) + PC_W'(swallow);
   assign pre_tick = (cnt == modv - PC_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n)        cnt <= '0;
      else if (pre_tick) cnt <= '0;
      else               cnt <= cnt + PC_W'(1);
   end

   p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt < modv));
endmodule

// File: rtl/pswl_swallow.sv
module pswl_swallow #(
   parameter int A_W = 6,
   parameter int B_W = 13
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           pre_tick,
   input  logic [A_W-1:0] a,
   input  logic [B_W-1:0] b,
   output logic           swallow,
   output logic           b_tick
);
   logic [B_W-1:0] k;
   logic [B_W-1:0] sw_seen;

   assign swallow = (k < B_W'(a));
   assign b_tick  = pre_tick && (k == b - B_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n)        k <= '0;
      else if (b_tick)   k <= '0;
      else if (pre_tick) k <= k + B_W'(1);
   end

   // Independent tally of P+1 periods per B cycle
   always_ff @(posedge clk) begin
      if (!rst_n)                    sw_seen <= '0;
      else if (b_tick)               sw_seen <= '0;
      else if (pre_tick && swallow)  sw_seen <= sw_seen + B_W'(1);
   end

   p_swallow_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
      b_tick |-> ((sw_seen + B_W'(swallow)) == B_W'(a)));

   p_no_reswallow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_tick && !swallow && !b_tick) |=> !swallow);
endmodule

// File: rtl/pswl_divider.sv
module pswl_divider #(
   parameter int A_W      = 6,
   parameter int B_W      = 13,
   parameter int PSEL_W   = 2,
   parameter int LOG2_MIN = 3,
   parameter int POST_DIV = 4,
   parameter int RST_A    = 0,
   parameter int RST_B    = 2,
   parameter int RST_PSEL = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [A_W-1:0]    a_val,
   input  logic [B_W-1:0]    b_val,
   input  logic [PSEL_W-1:0] pre_sel,
   output logic              div_pulse,
   output logic              cfg_err
);
   localparam int PC_W = LOG2_MIN + (1 << PSEL_W);
   localparam int Q_W  = (POST_DIV > 1) ? $clog2(POST_DIV) : 1;

   initial begin
      assert (B_W >= A_W) else $error("B_W must cover A_W");
      assert (POST_DIV >= 1) else $error("POST_DIV must be positive");
      assert (RST_B >= 2 && RST_A <= RST_B) else $error("illegal reset setting");
   end

   logic [A_W-1:0]    a_act;
   logic [B_W-1:0]    b_act;
   logic [PSEL_W-1:0] psel_act;
   logic              swallow, pre_tick, b_tick, wrap;

   pswl_cfg #(.A_W(A_W), .B_W(B_W), .PSEL_W(PSEL_W),
              .RST_A(RST_A), .RST_B(RST_B), .RST_PSEL(RST_PSEL)) u_cfg (
      .clk(clk), .rst_n(rst_n), .load(load), .a_in(a_val), .b_in(b_val),
      .psel_in(pre_sel), .boundary(wrap), .a_act(a_act), .b_act(b_act),
      .psel_act(psel_act), .cfg_err(cfg_err));

   pswl_prescaler #(.PC_W(PC_W), .PSEL_W(PSEL_W), .LOG2_MIN(LOG2_MIN)) u_pre (
      .clk(clk), .rst_n(rst_n), .psel(psel_act), .swallow(swallow),
      .pre_tick(pre_tick));

   pswl_swallow #(.A_W(A_W), .B_W(B_W)) u_swl (
      .clk(clk), .rst_n(rst_n), .pre_tick(pre_tick), .a(a_act), .b(b_act),
      .swallow(swallow), .b_tick(b_tick));

   generate
      if (POST_DIV == 1) begin : g_no_post
         assign wrap = b_tick;
      end else begin : g_post
         logic [Q_W-1:0] q;
         assign wrap = b_tick && (q == Q_W'(POST_DIV - 1));
         always_ff @(posedge clk) begin
            if (!rst_n)      q <= '0;
            else if (wrap)   q <= '0;
            else if (b_tick) q <= q + Q_W'(1);
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) div_pulse <= 1'b0;
      else        div_pulse <= wrap;
   end

   p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      div_pulse |=> !div_pulse);

   p_wrap_needs_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |-> (pre_tick && b_tick));
endmodule

// File: tb/pswl_divider_tb.sv
module pswl_divider_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load = 1'b0;
   logic [5:0]  a_val = '0;
   logic [12:0] b_val = 13'd2;
   logic [1:0]  pre_sel = '0;
   logic        div_pulse, cfg_err;

   int checks = 0;
   int failures = 0;
   string cur_req = "R1";

   // reference model state
   int  m_cnt, m_n_act, m_n_pend;
   bit  m_pend_v, m_pulse, m_err, m_started;

   always #2 clk = ~clk;

   pswl_divider u_dut (.clk(clk), .rst_n(rst_n), .load(load), .a_val(a_val),
      .b_val(b_val), .pre_sel(pre_sel), .div_pulse(div_pulse), .cfg_err(cfg_err));

   function automatic int ratio(int a, int b, int code);
      return 4 * (b * (8 << code) + a);
   endfunction

   always @(posedge clk) begin
      m_started = 1'b1;
      if (!rst_n) begin
         m_cnt = 0; m_n_act = ratio(0, 2, 0); m_pend_v = 0;
         m_pulse = 0; m_err = 0;
      end else begin
         m_cnt = m_cnt + 1;
         m_pulse = 0;
         if (m_cnt == m_n_act) begin
            m_pulse = 1; m_cnt = 0;
            if (m_pend_v) begin m_n_act = m_n_pend; m_pend_v = 0; end
         end
         if (load) begin
            if (int'(b_val) < 2 || int'(a_val) > int'(b_val)) m_err = 1;
            else begin
               m_err = 0; m_pend_v = 1;
               m_n_pend = ratio(int'(a_val), int'(b_val), int'(pre_sel));
            end
         end
      end
   end

   always @(negedge clk) begin
      if (m_started) begin
         checks++;
         if (div_pulse !== m_pulse) begin
            failures++;
            $display("FAIL %s div_pulse actual=%0b expected=%0b at %0t", cur_req, div_pulse, m_pulse, $time);
         end
         checks++;
         if (cfg_err !== m_err) begin
            failures++;
            $display("FAIL %s cfg_err actual=%0b expected=%0b at %0t", cur_req, cfg_err, m_err, $time);
         end
      end
   end

   task automatic cycles(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_load(int a, int b, int code);
      @(negedge clk);
      a_val = 6'(a); b_val = 13'(b); pre_sel = 2'(code); load = 1'b1;
      @(negedge clk);
      load = 1'b0;
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      #(4 * 150000);
      failures++;
      $display("FAIL watchdog expired during %s", cur_req);
      summary();
   end

   initial begin
      cycles(3);
      rst_n = 1'b1;
      @(negedge clk);
      checks++;   // R1 reset state, just after release
      if (div_pulse !== 1'b0 || cfg_err !== 1'b0) begin
         failures++;
         $display("FAIL R1 reset outputs actual=%0b%0b expected=00", div_pulse, cfg_err);
      end
      cycles(200);                       // R1 default ratio 64

      cur_req = "R3_R2";
      do_load(3, 5, 1);  cycles(1000);   // P=16, N=332
      do_load(1, 3, 2);  cycles(1200);   // P=32, N=388
      do_load(2, 2, 3);  cycles(1600);   // P=64, N=520
      do_load(0, 4, 0);  cycles(700);    // P=8,  N=128

      cur_req = "R5";
      do_load(0, 1, 2);  cycles(400);    // B<2 rejected
      cur_req = "R7";
      do_load(5, 6, 0);  cycles(600);    // clears error, N=212
      cur_req = "R6";
      do_load(9, 4, 1);  cycles(600);    // B<A rejected
      do_load(0, 0, 0);  cycles(300);    // B=0 also rejected

      cur_req = "R8";
      do_load(1, 2, 0);  cycles(30);     // pending mid-period
      do_load(4, 9, 0);  cycles(900);    // replaces pending, N=304
      do_load(63, 63, 0); cycles(5);     // largest A equal to B
      cycles(6000);

      cur_req = "R10";
      for (int n = 56; n <= 63; n++) begin
         do_load(n - 56, 7, 0);
         cycles(3 * 4 * n + 10);
      end

      cur_req = "R9";
      do_load(0, 64, 3); cycles(33000);  // P=64, N=16384
      summary();
   end
endmodule